// File: doc/BRIEF.md
# Partitioned Multi-Cell Time-to-Digital Combiner

This block is the digital back end of a time-to-digital converter built around a gated ring oscillator with a prime number of stages (47 by default). The ring only advances while the block holds its gate enable high, so the ring keeps its phase between measurements. A measurement runs as follows. A start strobe opens the gate. A stop strobe closes it. After a short settling delay, the block reports how many stage transitions the ring made while the gate was open.

The ring taps are registered once and then dealt out to seven measurement cells by interleaving. Stage `i` goes to cell `i mod NCELL`, so neighbouring stages never share a cell and each cell sees at most one of its taps in transition at a time. Every cell has four parts: a thermometer-style fine phase decoder scaled to its own tap count, a wrap counter, a snapshot register and a differencing stage. On the sample strobe, each cell outputs the phase it has gained since the previous sample. A registered adder tree, padded to a power of two, sums the cell outputs. The sum is then clamped to the output width.

The result leaves as a one-cycle `result_vld_o` pulse with the data held afterwards. There is no back-pressure. The downstream logic must take the value in the cycle the valid is high, and the value then stays on `result_o` until the next measurement.

Top module: `tdc_multicell_combiner`

## Requirements
- R1: With the window controller idle, a start strobe sampled on a clock edge drives `gate_en_o` high from that edge onward.
- R2: While the gate is open, a stop strobe closes the gate on the edge that samples it. A start strobe sampled while the gate is open, or while the block is settling, has no effect.
- R3: A stop strobe sampled while the controller is idle has no effect: the gate stays closed and no result is produced.
- R4: The tap encoding is as follows. Phase `q` runs from 0 to 2*NSTAGE-1. For `q` <= NSTAGE, stage `i` is high iff `i` < `q`. Otherwise, stage `i` is high iff `i` >= `q`-NSTAGE. Under this encoding, `result_o` equals the number of stage transitions made during the window, whatever the ring phase was when the window opened, including windows that wrap the ring several times.
- R5: Each cell unwraps correctly as long as the cell advances by fewer than twice its own tap count per clock. With the defaults, this covers ring advances of up to 70 transitions per clock.
- R6: A transition count above 2^OUT_W-1 (2047 by default) is reported as 2047 and does not wrap.
- R7: `result_vld_o` is a one-cycle pulse that occurs exactly once per measurement. `result_o` changes only on the edge that raises `result_vld_o`.
- R8: `result_vld_o` rises SETTLE_CYC + clog2(NCELL) + 1 clock edges after the edge that drops `gate_en_o`. This is 6 edges with the defaults.
- R9: After reset, `gate_en_o` is 0, `result_o` is 0 and `result_vld_o` is 0.
- R10: A window in which the ring does not advance gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that opens the measurement window |
| stop_i | input | 1 | Strobe that closes the measurement window |
| ring_taps_i | input | NSTAGE | Raw stage outputs of the gated ring |
| gate_en_o | output | 1 | Gate enable to the ring; the ring runs only while it is high |
| result_o | output | OUT_W | Saturated transition count of the last window |
| result_vld_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with its defaults: 47 stages over 7 cells, 8-bit wrap counters, an 11-bit result and a settling delay of 2. With these values, five cells own seven taps and two cells own six, so the decoder is exercised at two different phase scales. The 7-leaf sum also forces the tree to pad to 8 leaves. The ideal ring model in the bench advances anywhere from 0 to 70 transitions per clock. The 11-bit output can then be driven past its ceiling within a 60-cycle window, and back-to-back windows carry the ring phase through many full wraps.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_OPEN   = 2'd1,
    WIN_SETTLE = 2'd2
  } win_state_e;
endpackage

// File: rtl/tdc_window_ctl.sv
module tdc_window_ctl #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic gate_en_o,
  output logic strobe_o
);
  import tdc_pkg::*;

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  win_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gate_q;

  assign strobe_o  = (state_q == WIN_SETTLE) && (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign gate_en_o = gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      gate_q  <= 1'b0;
    end else begin
      case (state_q)
        WIN_IDLE: begin
          if (start_i) begin
            state_q <= WIN_OPEN;
            gate_q  <= 1'b1;
          end
        end
        WIN_OPEN: begin
          if (stop_i) begin
            state_q <= WIN_SETTLE;
            gate_q  <= 1'b0;
            cnt_q   <= '0;
          end
        end
        WIN_SETTLE: begin
          if (strobe_o) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= WIN_IDLE;
          gate_q  <= 1'b0;
        end
      endcase
    end
  end

  AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_IDLE && start_i) |=> gate_en_o); // R1
  AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o && stop_i) |=> !gate_en_o); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o && start_i && !stop_i) |=> gate_en_o); // R2
  AST_IDLE_STOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en_o && state_q == WIN_IDLE && stop_i && !start_i) |=> !gate_en_o); // R3
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (!gate_en_o && !$past(gate_en_o))); // R8
endmodule

// File: rtl/tdc_phase_cell.sv
module tdc_phase_cell #(
  parameter int TAPS   = 7,
  parameter int FW     = 4,
  parameter int WRAP_W = 8,
  parameter int CD_W   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] taps_i,
  input  logic            strobe_i,
  output logic [CD_W-1:0] diff_o,
  output logic            vld_o
);
  localparam int PHASES = 2 * TAPS;

  function automatic logic [FW-1:0] fine_of(input logic [TAPS-1:0] t);
    int ones;
    ones = 0;
    for (int j = 0; j < TAPS; j++) ones += int'(t[j]);
    if (t[TAPS-1]) return FW'(PHASES - ones);
    return FW'(ones);
  endfunction

  logic [FW-1:0]     fine_now;
  logic [FW-1:0]     fine_q, fine_snap_q;
  logic [WRAP_W-1:0] wrap_q, wrap_snap_q;
  logic [WRAP_W-1:0] wrap_delta;
  logic [CD_W-1:0]   gained;

  assign fine_now   = fine_of(taps_i);
  assign wrap_delta = wrap_q - wrap_snap_q;
  assign gained     = CD_W'(wrap_delta) * CD_W'(PHASES) + CD_W'(fine_q) - CD_W'(fine_snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q      <= '0;
      wrap_q      <= '0;
      fine_snap_q <= '0;
      wrap_snap_q <= '0;
      diff_o      <= '0;
      vld_o       <= 1'b0;
    end else begin
      fine_q <= fine_now;
      if (fine_now < fine_q) wrap_q <= wrap_q + 1'b1;
      vld_o <= strobe_i;
      if (strobe_i) begin
        diff_o      <= gained;
        fine_snap_q <= fine_q;
        wrap_snap_q <= wrap_q;
      end
    end
  end

  AST_WRAP_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wrap_q == $past(wrap_q) || wrap_q == WRAP_W'($past(wrap_q) + 1'b1))); // R5
  AST_FINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fine_q < FW'(PHASES)); // R4
endmodule

// File: rtl/tdc_sum_tree.sv
module tdc_sum_tree #(
  parameter int NIN   = 7,
  parameter int IN_W  = 13,
  parameter int OUT_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NIN*IN_W-1:0] in_flat_i,
  input  logic                in_vld_i,
  output logic [OUT_W-1:0]    result_o,
  output logic                result_vld_o
);
  localparam int LVL   = ($clog2(NIN) < 1) ? 1 : $clog2(NIN);
  localparam int NPAD  = 1 << LVL;
  localparam int SUM_W = IN_W + LVL;
  localparam logic [SUM_W-1:0] OUT_MAX = SUM_W'((1 << OUT_W) - 1);

  logic [SUM_W-1:0] leaf  [NPAD];
  logic [SUM_W-1:0] inner [NPAD-1];
  logic [LVL-1:0]   vpipe_q;

  for (genvar i = 0; i < NPAD; i++) begin : g_leaf
    if (i < NIN) begin : g_real
      assign leaf[i] = SUM_W'(in_flat_i[i*IN_W +: IN_W]);
    end else begin : g_pad
      assign leaf[i] = '0;
    end
  end

  for (genvar i = 0; i < NPAD - 1; i++) begin : g_node
    logic [SUM_W-1:0] lhs, rhs;
    if (2*i + 1 >= NPAD - 1) begin : g_from_leaf
      assign lhs = leaf[2*i + 1 - (NPAD - 1)];
      assign rhs = leaf[2*i + 2 - (NPAD - 1)];
    end else begin : g_from_node
      assign lhs = inner[2*i + 1];
      assign rhs = inner[2*i + 2];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inner[i] <= '0;
      else        inner[i] <= lhs + rhs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe_q      <= '0;
      result_o     <= '0;
      result_vld_o <= 1'b0;
    end else begin
      vpipe_q      <= LVL'({vpipe_q, in_vld_i});
      result_vld_o <= vpipe_q[LVL-1];
      if (vpipe_q[LVL-1])
        result_o <= (inner[0] > OUT_MAX) ? OUT_MAX[OUT_W-1:0] : inner[0][OUT_W-1:0];
    end
  end

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld_o && $past(inner[0] > OUT_MAX)) |-> (result_o == OUT_MAX[OUT_W-1:0])); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (result_vld_o || $stable(result_o))); // R7
endmodule

// File: rtl/tdc_multicell_combiner.sv
module tdc_multicell_combiner #(
  parameter int NSTAGE     = 47,
  parameter int NCELL      = 7,
  parameter int WRAP_W     = 8,
  parameter int OUT_W      = 11,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [NSTAGE-1:0] ring_taps_i,
  output logic              gate_en_o,
  output logic [OUT_W-1:0]  result_o,
  output logic              result_vld_o
);
  localparam int MAXM = (NSTAGE + NCELL - 1) / NCELL;
  localparam int FW   = $clog2(2 * MAXM);
  localparam int CD_W = WRAP_W + FW + 1;

  logic [NSTAGE-1:0]     taps_q;
  logic                  strobe;
  logic [NCELL-1:0]      cell_vld;
  logic [NCELL*CD_W-1:0] cell_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= ring_taps_i;
  end

  tdc_window_ctl #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .gate_en_o (gate_en_o),
    .strobe_o  (strobe)
  );

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    localparam int M = (NSTAGE - k + NCELL - 1) / NCELL;
    logic [M-1:0] sub;
    for (genvar j = 0; j < M; j++) begin : g_tap
      assign sub[j] = taps_q[k + NCELL*j];
    end
    tdc_phase_cell #(
      .TAPS   (M),
      .FW     (FW),
      .WRAP_W (WRAP_W),
      .CD_W   (CD_W)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .taps_i   (sub),
      .strobe_i (strobe),
      .diff_o   (cell_flat[k*CD_W +: CD_W]),
      .vld_o    (cell_vld[k])
    );
  end

  tdc_sum_tree #(
    .NIN   (NCELL),
    .IN_W  (CD_W),
    .OUT_W (OUT_W)
  ) u_tree (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_flat_i    (cell_flat),
    .in_vld_i     (&cell_vld),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
  );

  AST_CELLS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cell_vld) |-> (&cell_vld))); // R7
endmodule

// File: tb/test_tdc_multicell_combiner.sv
module test_tdc_multicell_combiner;
  localparam int NST = 47;
  localparam int PH  = 2 * NST;
  localparam int MAXR = 2047;
  localparam int LAT  = 6; // R8: 2 + clog2(7) + 1

  // {step per clock, open cycles}
  localparam logic [15:0] VEC [8] = '{
    {8'd0,  8'd4},  {8'd1,  8'd5},  {8'd7,  8'd3},  {8'd13, 8'd20},
    {8'd3,  8'd40}, {8'd47, 8'd2},  {8'd70, 8'd8},  {8'd25, 8'd30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [NST-1:0] taps;
  logic gate_en, res_vld;
  logic [10:0] result;

  int n_chk = 0, n_err = 0;
  int phase = 0, moved = 0, step_cfg = 0;

  always #2 clk = ~clk;

  tdc_multicell_combiner i_tdc_multicell_combiner (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .ring_taps_i(taps), .gate_en_o(gate_en), .result_o(result), .result_vld_o(res_vld)
  );

  // ideal ring: advances only while gated on
  always @(negedge clk) if (gate_en) begin
    phase = (phase + step_cfg) % PH;
    moved = moved + step_cfg;
  end

  always_comb
    for (int i = 0; i < NST; i++)
      taps[i] = (phase <= NST) ? (i < phase) : (i >= phase - NST);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic run_meas(input int step, input int open_cyc, input bit mid_start);
    int lat, exp, held, extra;
    step_cfg = step;
    moved = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(gate_en === 1'b1, "R1 gate open", int'(gate_en), 1);
    for (int c = 0; c < open_cyc; c++) begin
      if (mid_start && c == 1) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    if (mid_start) chk(gate_en === 1'b1, "R2 start ignored while open", int'(gate_en), 1);
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk(gate_en === 1'b0, "R2 gate closed", int'(gate_en), 0);
    if (mid_start) start = 1'b1; // R2: start during settling ignored
    lat = 0;
    while (!res_vld && lat < 40) begin
      @(negedge clk) start = 1'b0;
      lat++;
    end
    chk(lat == LAT, "R8 latency", lat, LAT);
    exp = (moved > MAXR) ? MAXR : moved;
    chk(int'(result) == exp, (moved > MAXR) ? "R6 saturated count" : "R4 count", int'(result), exp);
    held = int'(result);
    @(negedge clk);
    chk(res_vld === 1'b0, "R7 single pulse", int'(res_vld), 0);
    extra = 0;
    for (int c = 0; c < 6; c++) begin
      if (res_vld) extra++;
      @(negedge clk);
    end
    chk(extra == 0 && int'(result) == held, "R7 result held", int'(result), held);
    if (mid_start) chk(gate_en === 1'b0, "R2 settle start ignored", int'(gate_en), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int vcnt;
    repeat (3) @(negedge clk);
    chk(gate_en === 1'b0, "R9 reset gate", int'(gate_en), 0);
    chk(result === 11'd0, "R9 reset result", int'(result), 0);
    chk(res_vld === 1'b0, "R9 reset valid", int'(res_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      run_meas(int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
      if (VEC[v][15:8] == 8'd0) chk(result === 11'd0, "R10 frozen ring", int'(result), 0);
      if (VEC[v][15:8] == 8'd70) chk(int'(result) == moved, "R5 fast ring", int'(result), moved);
    end

    // R3: stop while idle
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk(gate_en === 1'b0, "R3 idle stop gate", int'(gate_en), 0);
    vcnt = 0;
    for (int c = 0; c < 12; c++) begin
      if (res_vld) vcnt++;
      @(negedge clk);
    end
    chk(vcnt == 0, "R3 idle stop no result", vcnt, 0);

    run_meas(5, 10, 1'b1);   // R2 ignored start strobes
    run_meas(60, 60, 1'b0);  // R6 saturation
    run_meas(9, 11, 1'b0);   // R4 after saturating window

    summary();
    $finish;
  end
endmodule